// File: doc/BRIEF.md
# Dual-Word SHA-256 Schedule Expander

This block turns one padded 512-bit message block into the full 64-word SHA-256 message schedule. It delivers two adjacent schedule words on every clock cycle, which suits a compression core that performs two rounds per cycle. The whole schedule therefore takes 32 consecutive cycles.

The block is controlled by a load strobe and a start strobe. While the block is idle, `load` captures the 512-bit block, and `start` begins emission. When both are asserted in the same cycle, the newly presented block is the one expanded. During a run, each cycle shows one pair on `w_even` and `w_odd`, qualified by `w_valid` and labelled by `pair_idx`. A one-cycle `done` pulse follows the final pair.

Internally the block holds a sliding 16-word window. It computes the two words that follow the window and then advances the window by two positions per cycle.

Top module: `sha256_sched_x2`

## Requirements
- R1: After reset, `w_valid` and `done` are 0 and `pair_idx` is 0.
- R2: Word i of the block (0..15) is `blk[511-32*i -: 32]`, so word 0 is bits [511:480] (big-endian order). For pairs 0 to 7, the outputs are these loaded words, unchanged.
- R3: For 16 <= t <= 63, W[t] = s1(W[t-2]) + W[t-7] + s0(W[t-15]) + W[t-16], with every sum taken modulo 2^32.
- R4: s0(x) = ROTR7(x) ^ ROTR18(x) ^ SHR3(x) and s1(x) = ROTR17(x) ^ ROTR19(x) ^ SHR10(x).
- R5: A run occupies 32 consecutive cycles with `w_valid` high. `pair_idx` counts 0 to 31, `w_even` carries W[2*pair_idx], and `w_odd` carries W[2*pair_idx+1].
- R6: A `start` sampled while idle makes pair 0 visible right after that clock edge.
- R7: When `load` and `start` are sampled together while idle, the block given in that same cycle is the one expanded.
- R8: A `load` sampled during a run is ignored, and the remaining pairs of the run are unchanged.
- R9: A `start` sampled during a run is ignored, and the run neither restarts nor stretches.
- R10: `done` is high for exactly the one cycle after pair 31, with `w_valid` low in that cycle unless a new run was started there. A `start` given in the `done` cycle begins a new run at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Capture `blk` when idle |
| blk | input | 512 | Padded message block, word 0 in the top bits |
| start | input | 1 | Begin expansion when idle |
| w_even | output | 32 | Schedule word W[2*pair_idx] |
| w_odd | output | 32 | Schedule word W[2*pair_idx+1] |
| w_valid | output | 1 | Output pair is valid |
| pair_idx | output | 5 | Index of the pair currently shown |
| done | output | 1 | One-cycle pulse after the last pair |

## Verification
Two pairs of functions can fall in the same cycle. The first is capture and start: asserting `load` and `start` together must expand the fresh block and not the stale window. The second is end and restart: a new `start` given in the cycle that `done` is high must yield pair 0 in the very next cycle, while `done` still pulses once. The bench provokes the first with load-and-start strobes and the second by firing a new block exactly when it sees `done`. Every pair that appears is judged against schedule words computed independently from the block. A further run injects a stray load and start mid-stream and expects the original sequence to go on untouched.

// File: rtl/sha256_sched_x2.sv
module sha256_sched_x2 #(
  parameter int WORD_W = 32,
  parameter int ROUNDS = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [16*WORD_W-1:0] blk,
  input  logic                 start,
  output logic [WORD_W-1:0]    w_even,
  output logic [WORD_W-1:0]    w_odd,
  output logic                 w_valid,
  output logic [$clog2(ROUNDS/2)-1:0] pair_idx,
  output logic                 done
);
  localparam int PAIRS = ROUNDS / 2;
  localparam int IW    = $clog2(PAIRS);
  localparam int BW    = 16 * WORD_W;
  localparam logic [IW-1:0] LAST = IW'(PAIRS - 1);

  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t sig0(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t sig1(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  word_t         win [16];
  logic          busy;
  logic [IW-1:0] pair;
  word_t         nxt0, nxt1;

  assign nxt0 = sig1(win[14]) + win[9]  + sig0(win[1]) + win[0];
  assign nxt1 = sig1(win[15]) + win[10] + sig0(win[2]) + win[1];

  assign w_even   = win[0];
  assign w_odd    = win[1];
  assign w_valid  = busy;
  assign pair_idx = pair;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pair <= '0;
      done <= 1'b0;
      for (int i = 0; i < 16; i++) win[i] <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (load)
          for (int i = 0; i < 16; i++) win[i] <= blk[BW-1-WORD_W*i -: WORD_W];
        if (start) begin
          busy <= 1'b1;
          pair <= '0;
        end
      end else begin
        for (int i = 0; i < 14; i++) win[i] <= win[i+2];
        win[14] <= nxt0;
        win[15] <= nxt1;
        if (pair == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
          pair <= '0;
        end else begin
          pair <= pair + 1'b1;
        end
      end
    end
  end

  p_idx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (w_valid && pair_idx != LAST) |=> (w_valid && pair_idx == $past(pair_idx) + 1'b1));

  p_slide_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (w_valid && pair_idx != LAST) |=> (w_even == $past(win[2]) && w_odd == $past(win[3])));

  p_run_begin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(w_valid) |-> (pair_idx == '0));

  p_end_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (w_valid && pair_idx == LAST) |=> done);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (w_valid && pair_idx != LAST && start) |=> (pair_idx != '0));
endmodule

// File: tb/sim_sha256_sched_x2.sv
module sim_sha256_sched_x2;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load = 1'b0;
  logic [511:0] blk = '0;
  logic         start = 1'b0;
  logic [31:0]  w_even, w_odd;
  logic         w_valid;
  logic [4:0]   pair_idx;
  logic         done;

  int checks = 0;
  int bad = 0;
  int pairs_seen = 0;
  int cyc = 0;
  bit expect_done = 1'b0;
  logic [68:0] q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sha256_sched_x2 u0 (
    .clk(clk), .rst_n(rst_n), .load(load), .blk(blk), .start(start),
    .w_even(w_even), .w_odd(w_odd), .w_valid(w_valid), .pair_idx(pair_idx), .done(done)
  );

  // R4 model
  function automatic logic [31:0] m_s0(input logic [31:0] x);
    return {x[6:0], x[31:7]} ^ {x[17:0], x[31:18]} ^ {3'b0, x[31:3]};
  endfunction
  function automatic logic [31:0] m_s1(input logic [31:0] x);
    return {x[16:0], x[31:17]} ^ {x[18:0], x[31:19]} ^ {10'b0, x[31:10]};
  endfunction

  // R2 / R3 model
  function automatic logic [31:0] ref_w(input logic [511:0] b, input int t);
    logic [31:0] w [64];
    for (int i = 0; i < 64; i++) begin
      if (i < 16) w[i] = b[511-32*i -: 32];
      else w[i] = m_s1(w[i-2]) + w[i-7] + m_s0(w[i-15]) + w[i-16];
    end
    return w[t];
  endfunction

  task automatic push_run(input logic [511:0] b);
    for (int p = 0; p < 32; p++)
      q.push_back({p[4:0], ref_w(b, 2*p), ref_w(b, 2*p+1)});
  endtask

  task automatic fin();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; bad++;
      $display("FAIL watchdog: run did not end, actual cyc=%0d expected <100000", cyc);
      fin();
    end
  end

  // monitor
  always @(negedge clk) if (rst_n) begin
    if (expect_done) begin
      checks++;
      if (done !== 1'b1) begin
        bad++; $display("FAIL R10 done after last pair: actual=%b expected=1", done);
      end
      if (!w_valid) begin
        checks++;
      end
      expect_done = 1'b0;
    end else if (done !== 1'b0) begin
      checks++; bad++;
      $display("FAIL R10 stray done: actual=%b expected=0", done);
    end
    if (w_valid) begin
      logic [68:0] e;
      pairs_seen++;
      checks++;
      if (q.size() == 0) begin
        bad++;
        $display("FAIL R9 unexpected pair: actual idx=%0d expected none", pair_idx);
      end else begin
        e = q.pop_front();
        if ({pair_idx, w_even, w_odd} !== e) begin
          bad++;
          $display("FAIL R2/R3/R5 pair: actual=%0d %h %h expected=%0d %h %h",
                   pair_idx, w_even, w_odd, e[68:64], e[63:32], e[31:0]);
        end
        if (e[68:64] == 5'd31) expect_done = 1'b1;
      end
    end
  end

  task automatic wait_done();
    do @(negedge clk); while (done !== 1'b1);
  endtask

  initial begin
    logic [511:0] ba, bb, bc, bd, be, bf;
    logic [31:0] s;
    s = 32'h1234_5678;
    for (int i = 0; i < 16; i++) begin
      ba[511-32*i -: 32] = 32'h0101_0101 * i;
      s = s * 32'd1664525 + 32'd1013904223; bb[511-32*i -: 32] = s;
      s = s * 32'd1664525 + 32'd1013904223; bc[511-32*i -: 32] = s;
      s = s * 32'd1664525 + 32'd1013904223; bf[511-32*i -: 32] = s;
    end
    bd = '1;
    be = {32'h8000_0000, 448'b0, 32'h0000_0000};

    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (w_valid !== 1'b0 || done !== 1'b0 || pair_idx !== 5'd0) begin
      bad++;
      $display("FAIL R1 reset: actual v=%b d=%b idx=%0d expected 0 0 0", w_valid, done, pair_idx);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R6: separate load then start
    load = 1'b1; blk = ba;
    @(negedge clk);
    load = 1'b0; blk = bd; start = 1'b1; push_run(ba);
    @(negedge clk);
    start = 1'b0;
    wait_done();
    repeat (2) @(negedge clk);

    // R7: load and start in one cycle
    load = 1'b1; start = 1'b1; blk = bb; push_run(bb);
    @(negedge clk);
    load = 1'b0; start = 1'b0; blk = bd;
    wait_done();
    @(negedge clk);

    // R8 and R9: stray load and start mid-run are ignored
    load = 1'b1; start = 1'b1; blk = bc; push_run(bc);
    @(negedge clk);
    load = 1'b0; start = 1'b0;
    repeat (5) @(negedge clk);
    load = 1'b1; start = 1'b1; blk = bd;
    @(negedge clk);
    load = 1'b0; start = 1'b0;
    repeat (20) @(negedge clk);
    load = 1'b1; blk = be;
    @(negedge clk);
    load = 1'b0;
    wait_done();
    @(negedge clk);

    // R10: run, then restart in the done cycle
    load = 1'b1; start = 1'b1; blk = bd; push_run(bd);
    @(negedge clk);
    load = 1'b0; start = 1'b0;
    wait_done();
    load = 1'b1; start = 1'b1; blk = be; push_run(be);
    @(negedge clk);
    load = 1'b1; start = 1'b0; blk = bf;
    @(negedge clk);
    load = 1'b0;
    wait_done();
    repeat (3) @(negedge clk);

    checks++;
    if (q.size() != 0 || pairs_seen != 160) begin
      bad++;
      $display("FAIL R5 pair count: actual seen=%0d left=%0d expected seen=160 left=0",
               pairs_seen, q.size());
    end
    fin();
  end
endmodule